// File: doc/BRIEF.md
# Programmable Processor Watchdog with Output Steering

This block supervises a processor by expecting it to touch a watchdog configuration register before a programmed interval runs out. The interval is a five-bit multiplier times one of four resolution steps, all counted in periods of a 16 Hz time-base strobe. When the interval runs out, one configuration bit steers the event to one of two outputs. The first is a latched interrupt request that software acknowledges. The second is a timed reset-pulse request, which also clears the configuration and asks a neighbouring block to clear its frequency-test bit.

Software reaches the block through a simple access strobe. The strobe selects either the watchdog configuration register or the flags register, and gives read or write. A synchronous power-up event returns everything to the disabled state. The core is a four-state machine:
- `S_OFF`: disabled.
- `S_RUN`: counting ticks.
- `S_TRIP`: interrupt latched, counting halted.
- `S_PULSE`: reset request active.

The transitions are:
- arm: `S_OFF`→`S_RUN` on a write with a nonzero multiplier.
- disarm: any state except `S_PULSE`→`S_OFF` on a write with a zero multiplier.
- kick: stay in `S_RUN` on any watchdog-register access.
- trip: `S_RUN`→`S_TRIP` on timeout with steering 0.
- fire: `S_RUN`→`S_PULSE` on timeout with steering 1.
- resume: `S_TRIP`→`S_RUN` on an access.
- release: `S_PULSE`→`S_RUN` or `S_OFF` after the pulse length.
- power-up: any state→`S_OFF`.

Top module: `wdog_steer`

## Requirements
- R1: After reset `wd_cfg` is 00h, and `wd_flag`, `wd_irq`, `wd_rst_pulse` and `ft_clear` are all low.
- R2: Configuration layout: bit 7 is steering (0 = interrupt, 1 = reset pulse), bits 6..2 are the multiplier, and bits 1..0 are the resolution. A write appears on `wd_cfg` in the cycle after the access.
- R3: A multiplier of zero disables the watchdog for any resolution, including the value 00h. No timeout occurs however many ticks arrive.
- R4: The timeout occurs on the N-th tick after the last restart. N is the multiplier times 1, 4, 16 or 64 for resolution 00, 01, 10 or 11. The outputs change in the cycle after that tick is sampled.
- R5: Any read or write of the watchdog register restarts the count. An access in the same cycle as the final tick takes priority, and no timeout occurs.
- R6: With steering 0, a timeout sets `wd_flag` and `wd_irq`. Both stay high, and counting halts, until the flags register is read or the watchdog register is accessed. A watchdog-register access also restarts counting.
- R7: With steering 1, a timeout sets `wd_flag` and raises `wd_rst_pulse` for exactly PULSE_TICKS ticks, while `wd_irq` stays low.
- R8: With steering 1, the timeout clears `wd_cfg` to 00h and gives a one-cycle `ft_clear` pulse. No further timeout follows.
- R9: `pwr_up` clears the configuration, the flag and the interrupt, and ends any reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up | input | 1 | Synchronous power-up event |
| tick16 | input | 1 | One-cycle strobe at 16 Hz |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_flags | input | 1 | 1 = flags register, 0 = watchdog register |
| acc_wdata | input | 8 | Write data |
| wd_cfg | output | 8 | Current configuration register value |
| wd_flag | output | 1 | Watchdog timeout flag |
| wd_irq | output | 1 | Latched interrupt request |
| wd_rst_pulse | output | 1 | Reset pulse request, active high |
| ft_clear | output | 1 | One-cycle request to clear the frequency-test bit |

## Verification
The assertions assume that `tick16` and `acc_valid` are single-cycle strobes sampled on the clock. They also assume that `pwr_up` is only raised while the block is out of reset. The bench drives every input just after a rising edge, and it pulses `tick16` for one cycle per tick, with idle cycles between accesses. Ticks run back to back so that the longest interval stays short in cycles. Every expected value is derived from the tick count and the register layout alone.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_RUN   = 2'd1,
        S_TRIP  = 2'd2,
        S_PULSE = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdog_limit.sv
// Interval length in ticks: multiplier scaled by four to the power of the resolution.
module wdog_limit #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
    input  logic [MULT_W-1:0] mult,
    input  logic [RES_W-1:0]  res,
    output logic [CNT_W-1:0]  limit
);
    localparam int NSTEP = 1 << RES_W;

    logic [CNT_W-1:0] scaled [NSTEP];

    for (genvar g = 0; g < NSTEP; g++) begin : g_scale
        assign scaled[g] = CNT_W'(mult) << (2 * g);
    end

    assign limit = scaled[res];
endmodule

// File: rtl/wdog_counter.sv
// Tick counter; hit is raised on the step that reaches the target.
module wdog_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] target,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    assign hit = step && ((cnt_q + W'(1)) == target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || hit) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer #(
    parameter int MULT_W      = 5,
    parameter int RES_W       = 2,
    parameter int PULSE_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_up,
    input  logic       tick16,
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic       acc_flags,
    input  logic [7:0] acc_wdata,
    output logic [7:0] wd_cfg,
    output logic       wd_flag,
    output logic       wd_irq,
    output logic       wd_rst_pulse,
    output logic       ft_clear
);
    import wdog_pkg::*;

    localparam int CNT_W   = MULT_W + 2 * ((1 << RES_W) - 1);
    localparam int PULSE_W = $clog2(PULSE_TICKS + 1);
    localparam int STEER_B = MULT_W + RES_W;

    wd_state_e        state_q, state_d;
    logic [7:0]       cfg_q, cfg_d;
    logic             wd_acc, wd_wr, fl_rd;
    logic             per_step, per_hit, pul_step, pul_hit;
    logic             trip_evt, fire_evt;
    logic [CNT_W-1:0] limit;
    logic             flag_q, irq_q, ftc_q;

    assign wd_acc = acc_valid && !acc_flags;
    assign wd_wr  = wd_acc && acc_write;
    assign fl_rd  = acc_valid && acc_flags && !acc_write;

    wdog_limit #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_limit (
        .mult  (cfg_q[STEER_B-1:RES_W]),
        .res   (cfg_q[RES_W-1:0]),
        .limit (limit)
    );

    assign per_step = tick16 && (state_q == S_RUN) && !wd_acc && !pwr_up;

    wdog_counter #(.W(CNT_W)) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (wd_acc || pwr_up || (state_q != S_RUN)),
        .step   (per_step),
        .target (limit),
        .hit    (per_hit)
    );

    assign pul_step = tick16 && (state_q == S_PULSE) && !pwr_up;

    wdog_counter #(.W(PULSE_W)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pwr_up || (state_q != S_PULSE)),
        .step   (pul_step),
        .target (PULSE_W'(PULSE_TICKS)),
        .hit    (pul_hit)
    );

    assign trip_evt = per_hit && !cfg_q[STEER_B];
    assign fire_evt = per_hit &&  cfg_q[STEER_B];

    // Configuration register next value
    always_comb begin
        cfg_d = cfg_q;
        if (pwr_up)        cfg_d = '0;
        else if (wd_wr)    cfg_d = acc_wdata;
        else if (fire_evt) cfg_d = '0;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF: begin
                if (wd_wr && (cfg_d[STEER_B-1:RES_W] != '0)) state_d = S_RUN;
            end
            S_RUN: begin
                if (wd_acc)        state_d = (cfg_d[STEER_B-1:RES_W] != '0) ? S_RUN : S_OFF;
                else if (fire_evt) state_d = S_PULSE;
                else if (trip_evt) state_d = S_TRIP;
            end
            S_TRIP: begin
                if (wd_acc) state_d = (cfg_d[STEER_B-1:RES_W] != '0) ? S_RUN : S_OFF;
            end
            S_PULSE: begin
                if (pul_hit) state_d = (cfg_d[STEER_B-1:RES_W] != '0) ? S_RUN : S_OFF;
            end
        endcase
        if (pwr_up) state_d = S_OFF;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
            ftc_q  <= 1'b0;
        end else if (pwr_up) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
            ftc_q  <= 1'b0;
        end else begin
            ftc_q <= fire_evt;
            if (trip_evt || fire_evt) flag_q <= 1'b1;
            else if (fl_rd || wd_acc) flag_q <= 1'b0;
            if (trip_evt)             irq_q <= 1'b1;
            else if (fl_rd || wd_acc) irq_q <= 1'b0;
        end
    end

    assign wd_cfg       = cfg_q;
    assign wd_flag      = flag_q;
    assign wd_irq       = irq_q;
    assign wd_rst_pulse = (state_q == S_PULSE);
    assign ft_clear     = ftc_q;
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_up,
    input logic       acc_valid,
    input logic       acc_flags,
    input logic [7:0] wd_cfg,
    input logic       wd_flag,
    input logic       wd_irq,
    input logic       wd_rst_pulse,
    input logic       ft_clear
);
    // R8: entering the reset pulse comes with a frequency-test clear request
    a_r8_ftc_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst_pulse) |-> ft_clear);

    // R8: configuration is zero when the pulse begins
    a_r8_cfg_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst_pulse) |-> (wd_cfg == 8'h00));

    // R5 R6: a watchdog-register access always drops the interrupt
    a_r6_irq_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_flags && !pwr_up) |=> !wd_irq);

    // R3: an interrupt can only rise with a nonzero multiplier configured
    a_r3_no_irq_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_irq) |-> (wd_cfg[6:2] != 5'd0));

    // R6: interrupt implies flag
    a_r6_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> wd_flag);

    // R7: interrupt and reset pulse are never requested together
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wd_irq && wd_rst_pulse));

    // R9: power-up clears everything
    a_r9_pwr_up: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_up |=> (wd_cfg == 8'h00 && !wd_flag && !wd_irq && !wd_rst_pulse && !ft_clear));
endmodule

bind wdog_steer wdog_steer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_up       (pwr_up),
    .acc_valid    (acc_valid),
    .acc_flags    (acc_flags),
    .wd_cfg       (wd_cfg),
    .wd_flag      (wd_flag),
    .wd_irq       (wd_irq),
    .wd_rst_pulse (wd_rst_pulse),
    .ft_clear     (ft_clear)
);

// File: tb/wdog_steer_tb.sv
`timescale 1ns/1ps
module wdog_steer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_up = 1'b0;
    logic       tick16 = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic       acc_flags = 1'b0;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] wd_cfg;
    logic       wd_flag, wd_irq, wd_rst_pulse, ft_clear;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic       irq;
        logic       flag;
        logic       rst;
        logic       ftc;
        logic [7:0] cfg;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    wdog_steer #(.MULT_W(5), .RES_W(2), .PULSE_TICKS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .tick16(tick16),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_flags(acc_flags),
        .acc_wdata(acc_wdata), .wd_cfg(wd_cfg), .wd_flag(wd_flag),
        .wd_irq(wd_irq), .wd_rst_pulse(wd_rst_pulse), .ft_clear(ft_clear)
    );

    // Monitor: pop one expectation per falling edge and compare
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (wd_irq !== e.irq || wd_flag !== e.flag || wd_rst_pulse !== e.rst ||
                ft_clear !== e.ftc || wd_cfg !== e.cfg) begin
                errors++;
                $display("FAIL %s: got irq=%b flag=%b rst=%b ftc=%b cfg=%02h exp irq=%b flag=%b rst=%b ftc=%b cfg=%02h",
                         e.tag, wd_irq, wd_flag, wd_rst_pulse, ft_clear, wd_cfg,
                         e.irq, e.flag, e.rst, e.ftc, e.cfg);
            end
        end
    end

    task automatic cyc(input logic v, input logic w, input logic f,
                       input logic [7:0] d, input logic t, input logic p);
        @(posedge clk);
        #1;
        acc_valid = v; acc_write = w; acc_flags = f; acc_wdata = d;
        tick16 = t; pwr_up = p;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic wd_write(input logic [7:0] d);
        cyc(1'b1, 1'b1, 1'b0, d, 1'b0, 1'b0);
    endtask

    task automatic wd_read();
        cyc(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic flags_read();
        cyc(1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
    endtask

    // Driver: let the last edge pass, then queue the expectation for the next falling edge
    task automatic expect_now(input string tag, input logic irq, input logic flag,
                              input logic rst, input logic ftc, input logic [7:0] cfg);
        exp_t e;
        idle();
        e.tag = tag; e.irq = irq; e.flag = flag; e.rst = rst; e.ftc = ftc; e.cfg = cfg;
        q.push_back(e);
        @(negedge clk);
        #0.1;
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: got run still active exp finished");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        expect_now("R1 reset state", 0, 0, 0, 0, 8'h00);
        ticks(100);
        expect_now("R3 disabled after reset", 0, 0, 0, 0, 8'h00);

        // Interrupt mode: mult 3, res 1 s -> 48 ticks
        wd_write(8'h0E);
        expect_now("R2 write visible", 0, 0, 0, 0, 8'h0E);
        ticks(47);
        expect_now("R4 one tick short", 0, 0, 0, 0, 8'h0E);
        ticks(1);
        expect_now("R4 R6 timeout irq", 1, 1, 0, 0, 8'h0E);
        ticks(100);
        expect_now("R6 irq latched, counting halted", 1, 1, 0, 0, 8'h0E);
        flags_read();
        expect_now("R6 flags read clears", 0, 0, 0, 0, 8'h0E);
        ticks(100);
        expect_now("R6 halted after flags read", 0, 0, 0, 0, 8'h0E);
        wd_read();
        ticks(47);
        expect_now("R5 read restarts count", 0, 0, 0, 0, 8'h0E);
        ticks(1);
        expect_now("R4 second timeout", 1, 1, 0, 0, 8'h0E);
        wd_read();
        expect_now("R6 register read clears irq", 0, 0, 0, 0, 8'h0E);

        // Restart mid-count and at the final tick: mult 1, res 01 -> 4 ticks
        wd_write(8'h05);
        ticks(3);
        cyc(1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        expect_now("R5 access beats final tick", 0, 0, 0, 0, 8'h05);
        ticks(3);
        expect_now("R5 count restarted", 0, 0, 0, 0, 8'h05);
        ticks(1);
        expect_now("R4 4-tick timeout", 1, 1, 0, 0, 8'h05);

        // Resolution 00: mult 2 -> 2 ticks
        wd_write(8'h08);
        expect_now("R6 write clears irq", 0, 0, 0, 0, 8'h08);
        ticks(1);
        expect_now("R4 res00 short", 0, 0, 0, 0, 8'h08);
        ticks(1);
        expect_now("R4 res00 timeout", 1, 1, 0, 0, 8'h08);

        // Resolution 11: mult 1 -> 64 ticks
        wd_write(8'h07);
        ticks(63);
        expect_now("R4 res11 short", 0, 0, 0, 0, 8'h07);
        ticks(1);
        expect_now("R4 res11 timeout", 1, 1, 0, 0, 8'h07);

        // Zero multiplier with nonzero resolution
        wd_write(8'h03);
        ticks(300);
        expect_now("R3 zero multiplier disabled", 0, 0, 0, 0, 8'h03);

        // 00h disables a running count
        wd_write(8'h0E);
        ticks(40);
        wd_write(8'h00);
        ticks(100);
        expect_now("R3 write 00h disables", 0, 0, 0, 0, 8'h00);

        // Reset-pulse mode: steer, mult 1, res 00 -> 1 tick
        wd_write(8'h84);
        expect_now("R2 steer write", 0, 0, 0, 0, 8'h84);
        ticks(1);
        expect_now("R7 R8 pulse starts, cfg cleared", 0, 1, 1, 1, 8'h00);
        expect_now("R8 ft_clear one cycle", 0, 1, 1, 0, 8'h00);
        ticks(1);
        expect_now("R7 pulse after one tick", 0, 1, 1, 0, 8'h00);
        ticks(1);
        expect_now("R7 pulse ends after two ticks", 0, 1, 0, 0, 8'h00);
        ticks(200);
        expect_now("R8 no repeat after pulse", 0, 1, 0, 0, 8'h00);
        flags_read();
        expect_now("R6 flags read clears flag", 0, 0, 0, 0, 8'h00);

        // Power-up event
        wd_write(8'h0E);
        ticks(48);
        expect_now("R9 irq before power-up", 1, 1, 0, 0, 8'h0E);
        cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        expect_now("R9 power-up clears", 0, 0, 0, 0, 8'h00);
        ticks(100);
        expect_now("R9 disabled after power-up", 0, 0, 0, 0, 8'h00);

        // Power-up during a reset pulse
        wd_write(8'h84);
        ticks(1);
        expect_now("R7 pulse before power-up", 0, 1, 1, 1, 8'h00);
        cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        expect_now("R9 power-up ends pulse", 0, 0, 0, 0, 8'h00);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule